// File: doc/BRIEF.md
# External Bus Transfer Sequencer

This block is the master side of a synchronous external memory bus. An internal requester hands it one read or write at a time, either as a single access or as a four-beat burst. The sequencer then drives the bus strobes: a one-clock start pulse, a direction line, the address, write data and a read output-enable. It watches the slave's acknowledge and error-acknowledge inputs to count beats and to end the cycle. Each acknowledged read beat is passed back to the requester with a one-clock valid pulse. At the end of the cycle the requester sees a done pulse, flagged as an error where that applies.

A bus-monitor counter guards every cycle. The requester supplies a limit with each request. The limit counts clocks from the start clock, and that start clock is clock 1. If a clock at or past the limit brings neither acknowledge nor error-acknowledge, the sequencer ends the cycle on its own with an error status.

All strobes come from registers and are active low. A request is taken only while the block is idle, so each cycle has exactly one outstanding transfer. The reset input is asynchronous and active low, and its release is expected to be already synchronised to the clock.

Top module: `ext_bus_seq`

## Requirements
- R1: `bus_start_n` is low for exactly the first clock of a cycle. That is the clock after the request was taken. It is high on every other clock.
- R2: `bus_rd_wr` (1 = read, 0 = write) and `bus_addr` take the request's values in the start clock. They stay unchanged on every clock up to and including the terminating clock.
- R3: On a read, `bus_oe_n` is high in the start clock. It is low on every later clock of the cycle up to the terminating clock, and it is high again once the cycle has ended.
- R4: On a write, `bus_oe_n` stays high for the whole cycle.
- R5: On a read, each clock in which `bus_ack_n` is low and `bus_err_n` is high gives one `rsp_rvalid` pulse in the next clock, carrying the `bus_rdata` sampled in that acknowledged clock.
- R6: A single read ends on its first acknowledge. A burst read ends on its fourth acknowledge.
- R7: A write ends on its first acknowledge, even if it was requested as a burst. It ends with `rsp_done` high and `rsp_err` low.
- R8: A clock with `bus_err_n` low ends the cycle at once with `rsp_done` and `rsp_err` both high. An acknowledge sampled in the same clock is ignored, so it produces no `rsp_rvalid`.
- R9: Take the clock numbered `tmo_limit`, counted from the start clock as 1, or any later clock. If such a clock has neither acknowledge nor error-acknowledge, the cycle ends there with `rsp_err` high. An acknowledge in that clock is honoured instead of a timeout.
- R10: `rsp_done` is a one-clock pulse in the clock after the terminating clock. `req_ready` is high exactly while idle. The next start pulse is therefore never in the clock in which `rsp_done` is high.
- R11: During reset, all bus strobes are inactive (`bus_start_n` and `bus_oe_n` high), `rsp_done` and `rsp_rvalid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data, held for the cycle |
| req_tmo | input | TMO_W | Bus monitor limit in clocks, 1 to 255 |
| bus_start_n | output | 1 | Transfer start strobe, active low |
| bus_rd_wr | output | 1 | Direction, 1 = read |
| bus_oe_n | output | 1 | Read output enable, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ack_n | input | 1 | Transfer acknowledge, active low |
| bus_err_n | input | 1 | Error acknowledge, active low |
| rsp_rvalid | output | 1 | One read beat delivered |
| rsp_rdata | output | DATA_W | Read beat data |
| rsp_done | output | 1 | Cycle finished, one-clock pulse |
| rsp_err | output | 1 | Cycle finished with error, qualifies rsp_done |

## Verification
The assertions take several things for granted about the inputs. They assume `req_tmo` is never zero. They also assume the slave's acknowledge and error-acknowledge have no effect outside a cycle, and that the requester holds nothing across the idle clock. The stimulus keeps `req_tmo` between 1 and 255. It drives acknowledge and error-acknowledge only in clocks that belong to an open cycle and releases them at once afterwards. It raises `req_valid` only in clocks where the bench expects `req_ready`.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ebs_beat_ctr.sv
module ebs_beat_ctr #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(BURST_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/ebs_bus_mon.sv
module ebs_bus_mon #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;
  localparam logic [TMO_W-1:0] CNT_ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q, cnt_d, lim_q;
  logic             cnt_en;

  // the start clock itself is clock 1; saturate so a late clock never wraps
  assign cnt_en = load | (run & (cnt_q != CNT_MAX));

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (load) cnt_d = CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lim_q <= CNT_ONE;
    else if (load) lim_q <= limit;
  end

  assign expire = (cnt_q >= lim_q);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int TMO_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TMO_W-1:0]  req_tmo,
  output logic              bus_start_n,
  output logic              bus_rd_wr,
  output logic              bus_oe_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack_n,
  input  logic              bus_err_n,
  output logic              rsp_rvalid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_err
);
  seq_state_e st_q, st_d;
  logic wr_q, burst_q;
  logic xfer_busy, accept;
  logic ack_hit, err_hit, tmo_hit, tmo_expire, beat_last;
  logic term_ok, term_err, term_any;
  logic start_n_d, oe_n_d, rvalid_d, done_d, err_d;

  assign xfer_busy = (st_q == ST_XFER);
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready & req_valid;

  // error-acknowledge masks acknowledge in the same clock
  assign err_hit  = xfer_busy & ~bus_err_n;
  assign ack_hit  = xfer_busy & ~bus_ack_n & bus_err_n;
  assign term_ok  = ack_hit & (wr_q | ~burst_q | beat_last);
  assign tmo_hit  = xfer_busy & tmo_expire & bus_ack_n & bus_err_n;
  assign term_err = err_hit | tmo_hit;
  assign term_any = term_ok | term_err;

  ebs_beat_ctr #(.BURST_LEN(BURST_LEN)) i_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (ack_hit & ~wr_q),
    .last  (beat_last)
  );

  ebs_bus_mon #(.TMO_W(TMO_W)) i_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .run    (xfer_busy & ~term_any),
    .limit  (req_tmo),
    .expire (tmo_expire)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_XFER;
      ST_XFER: if (term_any)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    start_n_d = ~accept;
    oe_n_d    = ~(xfer_busy & ~term_any & ~wr_q);
    rvalid_d  = ack_hit & ~wr_q;
    done_d    = term_any;
    err_d     = term_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      bus_start_n <= 1'b1;
      bus_oe_n    <= 1'b1;
      rsp_rvalid  <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_err     <= 1'b0;
    end else begin
      st_q        <= st_d;
      bus_start_n <= start_n_d;
      bus_oe_n    <= oe_n_d;
      rsp_rvalid  <= rvalid_d;
      rsp_done    <= done_d;
      rsp_err     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      burst_q   <= 1'b0;
      bus_rd_wr <= 1'b1;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (accept) begin
      wr_q      <= req_write;
      burst_q   <= req_burst;
      bus_rd_wr <= ~req_write;
      bus_addr  <= req_addr;
      bus_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_rdata <= '0;
    else if (rvalid_d) rsp_rdata <= bus_rdata;
  end
endmodule

// File: rtl/ebs_chk.sv
module ebs_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              xfer_busy,
  input logic              bus_start_n,
  input logic              bus_rd_wr,
  input logic              bus_oe_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack_n,
  input logic              bus_err_n,
  input logic              rsp_rvalid,
  input logic              rsp_done,
  input logic              rsp_err
);
  // R1
  start_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start_n |=> bus_start_n);

  // R2
  addr_dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && $past(xfer_busy)) |-> ($stable(bus_addr) && $stable(bus_rd_wr)));

  // R3
  oe_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start_n |-> bus_oe_n);

  // R3
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && bus_rd_wr && bus_start_n) |-> !bus_oe_n);

  // R4
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_wr |-> bus_oe_n);

  // R7
  write_one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !bus_rd_wr && !bus_ack_n && bus_err_n) |=> (rsp_done && !rsp_err && !rsp_rvalid));

  // R8
  err_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !bus_err_n) |=> (rsp_done && rsp_err && !rsp_rvalid));

  // R10
  no_start_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (bus_start_n && req_ready));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind ext_bus_seq ebs_chk #(.ADDR_W(ADDR_W)) i_ebs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .xfer_busy   (xfer_busy),
  .bus_start_n (bus_start_n),
  .bus_rd_wr   (bus_rd_wr),
  .bus_oe_n    (bus_oe_n),
  .bus_addr    (bus_addr),
  .bus_ack_n   (bus_ack_n),
  .bus_err_n   (bus_err_n),
  .rsp_rvalid  (rsp_rvalid),
  .rsp_done    (rsp_done),
  .rsp_err     (rsp_err)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, req_burst;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [TW-1:0] req_tmo;
  logic bus_start_n, bus_rd_wr, bus_oe_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, rsp_rdata;
  logic bus_ack_n, bus_err_n, rsp_rvalid, rsp_done, rsp_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ext_bus_seq #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(4), .TMO_W(TW)) i_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_tmo(req_tmo), .bus_start_n(bus_start_n),
    .bus_rd_wr(bus_rd_wr), .bus_oe_n(bus_oe_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack_n(bus_ack_n),
    .bus_err_n(bus_err_n), .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] beat_data(input logic [AW-1:0] a, input int b);
    return (a + DW'(b) * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // mode 0: random slave, 1: silent, 2: err+ack at clock sel, 3: ack only at clock sel
  task automatic run_txn(input bit wr, input bit burst, input logic [AW-1:0] addr,
                         input logic [TW-1:0] lim, input int mode, input int sel);
    int beats = 0;
    bit done = 0;
    chk("R10 ready before request", req_ready, 1'b1);
    req_valid = 1'b1; req_write = wr; req_burst = burst;
    req_addr = addr; req_wdata = ~addr; req_tmo = lim;
    tick();
    req_valid = 1'b0;
    chk("R1 start low", bus_start_n, 1'b0);
    chk("R2 address", bus_addr, addr);
    chk("R2 direction", bus_rd_wr, !wr);
    chk("R3 oe high in start clock", bus_oe_n, 1'b1);
    chk("R10 not ready while busy", req_ready, 1'b0);
    for (int k = 1; !done && k < 400; k++) begin
      bit a, e, term, exp_rv, exp_err;
      logic [DW-1:0] d;
      unique case (mode)
        0: begin a = ($urandom % 10) < 6; e = ($urandom % 25) == 0; end
        1: begin a = 1'b0; e = 1'b0; end
        2: begin a = (k == sel) || (k < sel); e = (k == sel); end
        default: begin a = (k == sel); e = 1'b0; end
      endcase
      d = beat_data(addr, beats);
      bus_ack_n = !a; bus_err_n = !e; bus_rdata = d;
      term = 0; exp_rv = 0; exp_err = 0;
      if (e) begin
        term = 1; exp_err = 1;
      end else if (a) begin
        exp_rv = !wr;
        beats++;
        if (wr || !burst || beats == 4) term = 1;
      end else if (k >= int'(lim)) begin
        term = 1; exp_err = 1;
      end
      tick();
      bus_ack_n = 1'b1; bus_err_n = 1'b1; bus_rdata = '0;
      chk(e ? "R8 no rvalid on error" : "R5 rvalid", rsp_rvalid, exp_rv);
      if (exp_rv) chk("R5 read data", rsp_rdata, d);
      chk(wr ? "R7 done" : "R6 done", rsp_done, term);
      if (term) chk(e ? "R8 error status" : "R9 status", rsp_err, exp_err);
      chk("R1 start high", bus_start_n, 1'b1);
      if (!term) begin
        chk(wr ? "R4 oe high" : "R3 oe low", bus_oe_n, wr);
        chk("R2 address held", bus_addr, addr);
        chk("R2 direction held", bus_rd_wr, !wr);
      end else begin
        chk("R3 oe released", bus_oe_n, 1'b1);
        chk("R10 ready after end", req_ready, 1'b1);
      end
      done = term;
    end
    tick();
    chk("R10 done one clock", rsp_done, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0;
    req_addr = '0; req_wdata = '0; req_tmo = 8'd8;
    bus_ack_n = 1'b1; bus_err_n = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 start idle", bus_start_n, 1'b1);
    chk("R11 oe idle", bus_oe_n, 1'b1);
    chk("R11 done idle", rsp_done, 1'b0);
    chk("R11 rvalid idle", rsp_rvalid, 1'b0);
    chk("R11 ready", req_ready, 1'b1);
    rst_n = 1'b1;
    tick();
    // directed corners
    run_txn(0, 0, 32'h0000_1000, 8'd8, 3, 1);   // R6 single read, ack in start clock
    run_txn(0, 1, 32'h0000_2000, 8'd20, 2, 5);  // R6 burst read, all four acks
    run_txn(1, 1, 32'h0000_3000, 8'd8, 3, 2);   // R7 burst write ends on first ack
    run_txn(0, 1, 32'h0000_4000, 8'd20, 2, 2);  // R8 err with ack, second clock
    run_txn(1, 0, 32'h0000_5000, 8'd8, 2, 1);   // R8 err on write
    run_txn(0, 0, 32'h0000_6000, 8'd1, 1, 0);   // R9 limit 1
    run_txn(1, 0, 32'h0000_7000, 8'd255, 1, 0); // R9 limit 255
    run_txn(0, 0, 32'h0000_8000, 8'd3, 3, 3);   // R9 ack on limit clock wins
    run_txn(0, 1, 32'h0000_9000, 8'd2, 3, 2);   // R9 mid-burst ack at limit, then timeout
    for (int i = 0; i < 300; i++) begin
      run_txn($urandom % 2, $urandom % 2, $urandom, TW'(1 + $urandom % 12), 0, 0);
      repeat ($urandom % 3) tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule